// File: doc/BRIEF.md
# Byte-Accessed Output Compare Unit

This block is one 16-bit output compare channel on an 8-bit register bus. Software loads a two-byte compare value through a high-byte register and a low-byte register. The block watches a free-running counter that comes in as an input. When the counter equals the loaded value, the block raises a compare flag and drives the compare pin to a level that software chose in advance.

The two byte registers follow a fixed write order. A write to the high byte stops all compare events until the low byte has also been written, so a value that is only half updated never fires. The flag has its own two-step release. Software first reads the status register while the flag is set. It then reads or writes the low compare byte, and only that second access clears the flag.

Two state machines carry the protocol. The write-order machine has the states HOLD and LIVE:
- Reset and any high-byte write go to HOLD.
- A low-byte write goes to LIVE.
- Compares run only in LIVE.

The flag-release machine has the states IDLE and ARMED:
- A status read while the flag is set moves IDLE to ARMED.
- Any low-byte access moves ARMED back to IDLE.
- The flag is cleared only during that ARMED-to-IDLE transition.

Top module: `ocmp_unit`

## Requirements
- R1: After reset the flag, the pin and the level bit are 0, and no compare event occurs until the low compare byte has been written (the write-order machine starts in HOLD).
- R2: While compares are enabled, a cycle in which `counter_i` equals {high byte, low byte} sets `flag_o` at the clock edge that ends that cycle.
- R3: At that same edge `pin_o` takes the value of the level bit. In every other cycle `pin_o` keeps its value.
- R4: A write to the high byte (select 2) blocks compare events from the following cycle. Compares resume in the cycle after a write to the low byte (select 3).
- R5: The flag clears only after a status read (select 0) made while the flag is set, followed by a read or write of the low byte. A low-byte access without that prior read leaves the flag set.
- R6: If a compare event occurs in the same cycle as the clearing low-byte access, the flag stays set.
- R7: Register map. A status read (select 0) returns bit 7 = flag and bit 0 = level, with all other bits 0. A status write sets the level bit from bit 0. Selects 2 and 3 read back the stored high and low bytes. Select 1 reads 0. `rdata_o` is 0 whenever `rd_i` is low. The compare bytes are not changed by reset.
- R8: A status read made while the flag is clear does not arm the clear. A flag that is set later survives a low-byte access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| counter_i | input | CNT_W | Free-running counter value |
| sel_i | input | 2 | Register select: 0 status, 1 unused, 2 compare high, 3 compare low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data (combinational) |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Output compare flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and an 8-bit bus. This gives exactly one high and one low byte, which is the split the write-order protocol assumes. Because the bench drives `counter_i` directly, it can place any counter value in any cycle. This lets it line up a compare event with a high-byte write, with a clearing low-byte access, or with a stale half-written value. Each of these orderings is reached in a single cycle rather than after thousands of counts.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_NONE = 2'd1,
        REG_CMPH = 2'd2,
        REG_CMPL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        WR_HOLD = 1'b0,
        WR_LIVE = 1'b1
    } wr_state_e;

    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_ARMED = 1'b1
    } fl_state_e;

    localparam int STAT_FLAG_BIT  = 7;
    localparam int STAT_LEVEL_BIT = 0;
endpackage

// File: rtl/ocmp_wr_seq.sv
module ocmp_wr_seq
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_wr_i,
    input  logic lo_wr_i,
    output logic live_o
);
    wr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_HOLD: if (lo_wr_i) state_d = WR_LIVE;
            WR_LIVE: if (hi_wr_i) state_d = WR_HOLD;
        endcase
    end

    always_comb begin
        live_o = (state_q == WR_LIVE);
    end

    assert_hi_write_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_i |=> !live_o);
    assert_lo_write_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_i |=> live_o);
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live_i,
    input  logic [CNT_W-1:0] counter_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             level_i,
    output logic             hit_o,
    output logic             pin_o
);
    always_comb begin
        hit_o = live_i && (counter_i == cmp_val_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     pin_o <= 1'b0;
        else if (hit_o) pin_o <= level_i;
    end

    assert_pin_takes_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (pin_o == $past(level_i)));
    assert_pin_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |=> $stable(pin_o));
    assert_no_hit_when_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !live_i |=> $stable(pin_o));
endmodule

// File: rtl/ocmp_flag_seq.sv
module ocmp_flag_seq
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic stat_rd_i,
    input  logic lo_acc_i,
    output logic flag_o
);
    fl_state_e state_q, state_d;
    logic      clear_req;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (stat_rd_i && flag_o) state_d = FL_ARMED;
            FL_ARMED: if (lo_acc_i)            state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        clear_req = (state_q == FL_ARMED) && lo_acc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (hit_i)     flag_o <= 1'b1;
        else if (clear_req) flag_o <= 1'b0;
    end

    assert_flag_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_o);
    assert_clear_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(state_q == FL_ARMED && lo_acc_i));
    assert_hit_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && clear_req) |=> flag_o);
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] counter_i,
    input  logic [1:0]       sel_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             pin_o,
    output logic             flag_o
);
    localparam int HI_W = CNT_W - BUS_W;

    reg_sel_e         sel;
    logic [HI_W-1:0]  cmp_hi_q;
    logic [BUS_W-1:0] cmp_lo_q;
    logic             level_q;
    logic             hi_wr, lo_wr, lo_acc, stat_rd, stat_wr;
    logic             live, hit;

    always_comb begin
        sel     = reg_sel_e'(sel_i);
        hi_wr   = wr_i && (sel == REG_CMPH);
        lo_wr   = wr_i && (sel == REG_CMPL);
        lo_acc  = (wr_i || rd_i) && (sel == REG_CMPL);
        stat_rd = rd_i && (sel == REG_STAT);
        stat_wr = wr_i && (sel == REG_STAT);
    end

    // compare bytes keep their contents through reset
    always_ff @(posedge clk) begin
        if (hi_wr) cmp_hi_q <= wdata_i[HI_W-1:0];
        if (lo_wr) cmp_lo_q <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       level_q <= 1'b0;
        else if (stat_wr) level_q <= wdata_i[STAT_LEVEL_BIT];
    end

    ocmp_wr_seq u_wr_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_wr_i (hi_wr),
        .lo_wr_i (lo_wr),
        .live_o  (live)
    );

    ocmp_match #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_i    (live),
        .counter_i (counter_i),
        .cmp_val_i ({cmp_hi_q, cmp_lo_q}),
        .level_i   (level_q),
        .hit_o     (hit),
        .pin_o     (pin_o)
    );

    ocmp_flag_seq u_flag_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .stat_rd_i (stat_rd),
        .lo_acc_i  (lo_acc),
        .flag_o    (flag_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel)
                REG_STAT: begin
                    rdata_o[STAT_FLAG_BIT]  = flag_o;
                    rdata_o[STAT_LEVEL_BIT] = level_q;
                end
                REG_NONE: rdata_o = '0;
                REG_CMPH: rdata_o = BUS_W'(cmp_hi_q);
                REG_CMPL: rdata_o = cmp_lo_q;
            endcase
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!flag_o && !pin_o));
    assert_idle_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/ocmp_unit_test.sv
`timescale 1ns/100ps
module ocmp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] counter = 16'h0000;
    logic [1:0]  sel = 2'd1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        pin, flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 flag, 1 pin, 2 rdata
        logic [7:0] val;
        string      req;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    ocmp_unit uut (
        .clk(clk), .rst_n(rst_n), .counter_i(counter), .sel_i(sel),
        .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
        .pin_o(pin), .flag_o(flag)
    );

    // monitor: drains expectations 1 ns after each falling edge
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = exp_q.pop_front();
            act = (it.kind == 0) ? {7'd0, flag} : (it.kind == 1) ? {7'd0, pin} : rdata;
            checks++;
            if (act !== it.val) begin
                fails++;
                $display("FAIL %s: actual %h expected %h (kind %0d)", it.req, act, it.val, it.kind);
            end
        end
    end

    task automatic expect_v(input int kind, input logic [7:0] val, input string req);
        item_t it;
        it.kind = kind; it.val = val; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic idle(input logic [15:0] c);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; sel = 2'd1; counter = c;
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d, input logic [15:0] c);
        @(negedge clk);
        wr = 1'b1; rd = 1'b0; sel = s; wdata = d; counter = c;
    endtask

    task automatic bus_rd(input logic [1:0] s, input logic [15:0] c);
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; sel = s; counter = c;
    endtask

    task automatic clear_flag();
        bus_rd(2'd0, 16'h0000);
        bus_rd(2'd3, 16'h0000);
        idle(16'h0000);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        counter = 16'h1234;
        repeat (3) @(negedge clk);
        idle(16'h1234);
        expect_v(0, 8'h00, "R1 flag at reset");
        expect_v(1, 8'h00, "R1 pin at reset");
        rst_n = 1'b1;
        bus_rd(2'd0, 16'h1234);
        expect_v(2, 8'h00, "R1 status after reset");
        idle(16'h1234);
        expect_v(0, 8'h00, "R1 no compare before low write");

        // level 1, load 0x1234
        bus_wr(2'd0, 8'h01, 16'h0000);
        bus_wr(2'd2, 8'h12, 16'h0000);
        bus_wr(2'd3, 8'h34, 16'h0000);
        idle(16'h1234);
        idle(16'h0000);
        expect_v(0, 8'h01, "R2 flag on match");
        expect_v(1, 8'h01, "R3 pin takes level 1");
        bus_rd(2'd0, 16'h0000);
        expect_v(2, 8'h81, "R7 status read flag+level");
        idle(16'h0000);
        expect_v(0, 8'h01, "R5 flag held after status read only");
        bus_wr(2'd3, 8'h34, 16'h0000);
        idle(16'h0000);
        expect_v(0, 8'h00, "R5 flag cleared by read then low write");

        // level 0, pin holds until next match
        bus_wr(2'd0, 8'h00, 16'h0000);
        idle(16'h0001);
        expect_v(1, 8'h01, "R3 pin holds without match");
        idle(16'h1234);
        idle(16'h0000);
        expect_v(1, 8'h00, "R3 pin takes level 0");
        expect_v(0, 8'h01, "R2 flag on second match");

        // low access without status read
        bus_rd(2'd3, 16'h0000);
        expect_v(2, 8'h34, "R7 low byte readback");
        idle(16'h0000);
        expect_v(0, 8'h01, "R5 low read without arm keeps flag");
        bus_rd(2'd2, 16'h0000);
        expect_v(2, 8'h12, "R7 high byte readback");
        bus_rd(2'd1, 16'h0000);
        expect_v(2, 8'h00, "R7 unused select reads 0");
        clear_flag();
        expect_v(0, 8'h00, "R5 flag cleared by read then low read");

        // status read with flag clear does not arm
        bus_rd(2'd0, 16'h0000);
        idle(16'h1234);
        idle(16'h0000);
        expect_v(0, 8'h01, "R8 flag set after unarmed read");
        bus_rd(2'd3, 16'h0000);
        idle(16'h0000);
        expect_v(0, 8'h01, "R8 low access after unarmed read keeps flag");
        clear_flag();
        expect_v(0, 8'h00, "R5 clear after R8 case");

        // high write holds compares
        bus_wr(2'd2, 8'h56, 16'h0000);
        idle(16'h5634);
        idle(16'h1234);
        idle(16'h0000);
        expect_v(0, 8'h00, "R4 no flag while held");
        expect_v(1, 8'h00, "R4 pin unchanged while held");
        bus_wr(2'd0, 8'h01, 16'h0000);
        bus_wr(2'd3, 8'h78, 16'h0000);
        idle(16'h5678);
        idle(16'h0000);
        expect_v(0, 8'h01, "R4 compares resume after low write");
        expect_v(1, 8'h01, "R4 pin after resume");

        // match during clear
        bus_rd(2'd0, 16'h0000);
        bus_rd(2'd3, 16'h5678);
        idle(16'h0000);
        expect_v(0, 8'h01, "R6 match wins over clear");
        clear_flag();
        expect_v(0, 8'h00, "R6 later clear works");
        bus_rd(2'd0, 16'h0000);
        expect_v(2, 8'h01, "R7 status level only");
        idle(16'h0000);
        expect_v(2, 8'h00, "R7 rdata zero without rd");

        // reset keeps compare bytes, re-holds compares
        rst_n = 1'b0;
        idle(16'h5678);
        idle(16'h5678);
        rst_n = 1'b1;
        idle(16'h5678);
        expect_v(0, 8'h00, "R1 flag after second reset");
        expect_v(1, 8'h00, "R1 pin after second reset");
        bus_rd(2'd2, 16'h5678);
        expect_v(2, 8'h56, "R7 high byte kept over reset");
        bus_rd(2'd3, 16'h5678);
        expect_v(2, 8'h78, "R7 low byte kept over reset");
        bus_rd(2'd0, 16'h5678);
        expect_v(2, 8'h00, "R1 level cleared by reset");
        idle(16'h0000);
        expect_v(0, 8'h00, "R1 held after reset despite match");
        bus_wr(2'd3, 8'h78, 16'h0000);
        idle(16'h5678);
        idle(16'h0000);
        expect_v(0, 8'h01, "R1 compare after low write");
        idle(16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule